// File: doc/BRIEF.md
# Eight-Bit ALU with Per-Operation Flag Policy

This block is the arithmetic and logic datapath of a small register-file microcontroller without an accumulator. Each cycle it takes an operation code, a destination operand and a source operand. It returns the combinational result, a write-enable that tells the register file whether to store that result, and the next value of the six condition flags. The flags live in a register inside the block. That register loads the next value on a clock edge when the enable is high, and those stored flags feed back into the following operation.

The flags are carry C, zero Z, sign S, overflow V, decimal-direction D and half-carry H. Each operation sets, clears or keeps each flag under its own rule. Compare and test operations change only the flags. The decimal adjust uses the stored D, H and C flags to correct the result of the previous BCD addition or subtraction.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 00h) gives dst+src, and ADC (op 01h) gives dst+src+C. Both write the result. C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, Z and S come from the result, and D is cleared.
- R2: SUB (op 02h) gives dst-src, and SBC (op 03h) gives dst-src-C. Both write the result. C is the borrow out of bit 7, H is the borrow into bit 4, V is two's-complement overflow, Z and S come from the result, and D is set.
- R3: CP (op 0Ah) works out dst-src and updates only C, Z, S and V as SUB would. D and H keep their values, and the write-enable stays low.
- R4: OR (04h), AND (05h) and XOR (0Bh) write the result. TM (07h, dst AND src) and TCM (06h, NOT dst AND src) do not write. All five update Z and S from the value, clear V, and keep C, D and H.
- R5: RL (10h) rotates left with C taking bit 7. RLC (11h) rotates left through carry. RR (12h) rotates right with C taking bit 0. RRC (13h) rotates right through carry. All four write the result, update Z and S, and set V when bit 7 changes. D and H are kept.
- R6: SRA (14h) keeps bit 7 and shifts right by one. C takes the old bit 0, Z and S are updated, V is cleared, and D and H are kept.
- R7: COM (15h) writes the bitwise inverse, updates Z and S, clears V and keeps C. SWAP (16h) exchanges the two nibbles, updates Z and S, and keeps C, V, D and H.
- R8: DA (17h) adds 06h to the operand when H=1 or the low nibble exceeds 9, and adds 60h when C=1 or the operand exceeds 99h, if D=0. If D=1, it subtracts 06h when H=1 and subtracts 60h when C=1. C ends set exactly when the 60h step applied. Z and S are updated, and V, D and H are kept.
- R9: INC (18h) and DEC (19h) write dst+1 and dst-1. They update Z, S and V, and keep C, D and H.
- R10: CCF (1Ah) inverts C, RCF (1Bh) clears C and SCF (1Ch) sets C. None of them writes or changes another flag.
- R11: Reset clears all flags. The flag register changes only on a clock edge with en_i high. An unused op code writes nothing and keeps every flag. Flag bit positions are C=5, Z=4, S=3, V=2, D=1, H=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| en_i | input | 1 | Load next flags on this clock edge |
| op_i | input | 5 | Operation code |
| dst_i | input | 8 | Destination operand |
| src_i | input | 8 | Source operand |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Result is to be written back |
| flags_nxt_o | output | 6 | Next flag value {C,Z,S,V,D,H} |
| flags_o | output | 6 | Stored flags {C,Z,S,V,D,H} |

## Verification
Some rules hold on every cycle, and the bound checker watches those. Compare and test never raise the write-enable. Every written result leaves Z and S that match it. The logic group clears V and keeps C, D and H. RL moves bit 7 into C, CCF flips only C, add clears D and subtract sets it, and the flags stay frozen while the enable is low. The rest depends on the flag history of earlier operations, and only the bench's ordered scenarios can show it. That covers carry and borrow chaining through ADC and SBC, half-carry and overflow values, rotates through carry, and the decimal adjust acting on the D, H and C left by a previous add or subtract.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'h00, OP_ADC  = 5'h01, OP_SUB  = 5'h02, OP_SBC  = 5'h03,
        OP_OR   = 5'h04, OP_AND  = 5'h05, OP_TCM  = 5'h06, OP_TM   = 5'h07,
        OP_CP   = 5'h0A, OP_XOR  = 5'h0B,
        OP_RL   = 5'h10, OP_RLC  = 5'h11, OP_RR   = 5'h12, OP_RRC  = 5'h13,
        OP_SRA  = 5'h14, OP_COM  = 5'h15, OP_SWAP = 5'h16, OP_DA   = 5'h17,
        OP_INC  = 5'h18, OP_DEC  = 5'h19, OP_CCF  = 5'h1A, OP_RCF  = 5'h1B,
        OP_SCF  = 5'h1C
    } alu_op_e;

    // Packed so that c lands in bit 5 and h in bit 0.
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } alu_state_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = alu8_pkg::DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam int NW = DW / 2;

    logic [DW:0] full;
    logic [NW:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
        sum   = full[DW-1:0];
        c_out = full[DW];
        h_out = low[NW];
        if (sub)
            v_out = (a[DW-1] != b[DW-1]) && (sum[DW-1] != a[DW-1]);
        else
            v_out = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = alu8_pkg::DW
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          c_out
);
    localparam int NW = DW / 2;

    always_comb begin
        res   = a;
        c_out = cin;
        case (op)
            OP_RL:   begin res = {a[DW-2:0], a[DW-1]}; c_out = a[DW-1]; end
            OP_RLC:  begin res = {a[DW-2:0], cin};     c_out = a[DW-1]; end
            OP_RR:   begin res = {a[0], a[DW-1:1]};    c_out = a[0];    end
            OP_RRC:  begin res = {cin, a[DW-1:1]};     c_out = a[0];    end
            OP_SRA:  begin res = {a[DW-1], a[DW-1:1]}; c_out = a[0];    end
            OP_COM:  res = ~a;
            OP_SWAP: res = {a[NW-1:0], a[DW-1:NW]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
    parameter int DW = alu8_pkg::DW
) (
    input  logic [DW-1:0] a,
    input  logic          c_in,
    input  logic          d_in,
    input  logic          h_in,
    output logic [DW-1:0] res,
    output logic          c_out
);
    localparam int NW = DW / 2;
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [DW-1:0] BYTE_MAX = {NIB_MAX, NIB_MAX};
    localparam logic [NW-1:0] FIX = NW'(6);

    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] corr;

    always_comb begin
        lo_fix = d_in ? h_in : (h_in || (a[NW-1:0] > NIB_MAX));
        hi_fix = d_in ? c_in : (c_in || (a > BYTE_MAX));
        corr   = {hi_fix ? FIX : '0, lo_fix ? FIX : '0};
        res    = d_in ? (a - corr) : (a + corr);
        c_out  = hi_fix;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = alu8_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    output logic [DW-1:0] result_o,
    output logic          wr_en_o,
    output logic [5:0]    flags_nxt_o,
    output logic [5:0]    flags_o
);
    alu_state_t    state_d, state_q;
    alu_op_e       op;
    logic [DW-1:0] as_b, as_sum, sh_res, da_res, val;
    logic          as_cin, as_sub, as_c, as_h, as_v, sh_c, da_c;
    logic          upd_zs, wr;

    assign op = alu_op_e'(op_i);

    // Operand steering for the shared adder/subtractor.
    always_comb begin
        as_b   = src_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = state_q.flags.c;
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = state_q.flags.c; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) addsub_i (
        .a(dst_i), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_shift #(.DW(DW)) shift_i (
        .op(op), .a(dst_i), .cin(state_q.flags.c),
        .res(sh_res), .c_out(sh_c)
    );

    alu8_decadj #(.DW(DW)) decadj_i (
        .a(dst_i), .c_in(state_q.flags.c), .d_in(state_q.flags.d),
        .h_in(state_q.flags.h), .res(da_res), .c_out(da_c)
    );

    // Per-operation flag policy.
    always_comb begin
        state_d = state_q;
        val     = '0;
        wr      = 1'b0;
        upd_zs  = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                val = as_sum; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.c = as_c;
                state_d.flags.v = as_v;
                state_d.flags.h = as_h;
                state_d.flags.d = as_sub;
            end
            OP_CP: begin
                val = as_sum; upd_zs = 1'b1;
                state_d.flags.c = as_c;
                state_d.flags.v = as_v;
            end
            OP_OR, OP_AND, OP_XOR, OP_TM, OP_TCM: begin
                case (op)
                    OP_OR:   val = dst_i | src_i;
                    OP_AND:  val = dst_i & src_i;
                    OP_XOR:  val = dst_i ^ src_i;
                    OP_TM:   val = dst_i & src_i;
                    default: val = ~dst_i & src_i;
                endcase
                wr = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
                upd_zs = 1'b1;
                state_d.flags.v = 1'b0;
            end
            OP_RL, OP_RLC, OP_RR, OP_RRC: begin
                val = sh_res; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.c = sh_c;
                state_d.flags.v = sh_res[DW-1] ^ dst_i[DW-1];
            end
            OP_SRA: begin
                val = sh_res; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.c = sh_c;
                state_d.flags.v = 1'b0;
            end
            OP_COM: begin
                val = sh_res; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.v = 1'b0;
            end
            OP_SWAP: begin
                val = sh_res; wr = 1'b1; upd_zs = 1'b1;
            end
            OP_DA: begin
                val = da_res; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.c = da_c;
            end
            OP_INC, OP_DEC: begin
                val = as_sum; wr = 1'b1; upd_zs = 1'b1;
                state_d.flags.v = as_v;
            end
            OP_CCF: state_d.flags.c = ~state_q.flags.c;
            OP_RCF: state_d.flags.c = 1'b0;
            OP_SCF: state_d.flags.c = 1'b1;
            default: ;
        endcase
        if (upd_zs) begin
            state_d.flags.z = (val == '0);
            state_d.flags.s = val[DW-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (en_i)
            state_q <= state_d;
    end

    assign result_o    = val;
    assign wr_en_o     = wr;
    assign flags_nxt_o = state_d.flags;
    assign flags_o     = state_q.flags;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int DW = alu8_pkg::DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic [4:0]    op_i,
    input logic [DW-1:0] dst_i,
    input logic [DW-1:0] result_o,
    input logic          wr_en_o,
    input logic [5:0]    flags_o
);
    // R3: compare never requests a write
    a_r3_cp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'h0A) |-> !wr_en_o);

    // R4: test operations never request a write
    a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 5'h06) || (op_i == 5'h07)) |-> !wr_en_o);

    // R4: logic group clears V and keeps C, D, H
    a_r4_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i inside {5'h04, 5'h05, 5'h06, 5'h07, 5'h0B}))
        |=> (flags_o[2] == 1'b0) && (flags_o[5] == $past(flags_o[5]))
            && (flags_o[1:0] == $past(flags_o[1:0])));

    // R1: add clears D
    a_r1_add_clears_d: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i inside {5'h00, 5'h01})) |=> !flags_o[1]);

    // R2: subtract sets D
    a_r2_sub_sets_d: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i inside {5'h02, 5'h03})) |=> flags_o[1]);

    // R5: RL moves bit 7 into carry
    a_r5_rl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i == 5'h10)) |=> (flags_o[5] == $past(dst_i[DW-1])));

    // R10: CCF flips only the carry
    a_r10_ccf_only_c: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i == 5'h1A))
        |=> (flags_o == {~$past(flags_o[5]), $past(flags_o[4:0])}));

    // R11: flags frozen while the enable is low
    a_r11_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(flags_o));

    // R11: a written result leaves matching Z and S
    a_r11_zs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_en_o)
        |=> (flags_o[4] == ($past(result_o) == '0))
            && (flags_o[3] == $past(result_o[DW-1])));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) chk_i (.*);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] dst_i = '0;
    logic [7:0] src_i = '0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [5:0] flags_nxt_o;
    logic [5:0] flags_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i),
        .dst_i(dst_i), .src_i(src_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
    );

    // {req, op, dst, src, result, write, flags C Z S V D H}
    localparam int NV = 42;
    localparam logic [39:0] VEC [NV] = '{
        {4'd1,  5'h00, 8'h12, 8'h34, 8'h46, 1'b1, 6'b000000}, // R1
        {4'd1,  5'h00, 8'h0F, 8'h01, 8'h10, 1'b1, 6'b000001}, // R1 half carry
        {4'd1,  5'h00, 8'h7F, 8'h01, 8'h80, 1'b1, 6'b001101}, // R1 overflow
        {4'd1,  5'h00, 8'hFF, 8'h01, 8'h00, 1'b1, 6'b110001}, // R1 carry, zero
        {4'd1,  5'h01, 8'h10, 8'h20, 8'h31, 1'b1, 6'b000000}, // R1 ADC uses C
        {4'd1,  5'h01, 8'h80, 8'h80, 8'h00, 1'b1, 6'b110100}, // R1
        {4'd2,  5'h03, 8'h50, 8'h20, 8'h2F, 1'b1, 6'b000011}, // R2 SBC uses C
        {4'd2,  5'h02, 8'h00, 8'h01, 8'hFF, 1'b1, 6'b101011}, // R2 borrow
        {4'd2,  5'h02, 8'h80, 8'h01, 8'h7F, 1'b1, 6'b000111}, // R2 overflow
        {4'd3,  5'h0A, 8'h05, 8'h05, 8'h00, 1'b0, 6'b010011}, // R3 equal
        {4'd3,  5'h0A, 8'h03, 8'h05, 8'h00, 1'b0, 6'b101011}, // R3 less
        {4'd4,  5'h05, 8'hF0, 8'h3C, 8'h30, 1'b1, 6'b100011}, // R4 AND
        {4'd4,  5'h04, 8'h80, 8'h01, 8'h81, 1'b1, 6'b101011}, // R4 OR
        {4'd4,  5'h0B, 8'hAA, 8'hAA, 8'h00, 1'b1, 6'b110011}, // R4 XOR
        {4'd4,  5'h07, 8'hFF, 8'h80, 8'h00, 1'b0, 6'b101011}, // R4 TM
        {4'd4,  5'h06, 8'hFF, 8'h0F, 8'h00, 1'b0, 6'b110011}, // R4 TCM
        {4'd10, 5'h1B, 8'h00, 8'h00, 8'h00, 1'b0, 6'b010011}, // R10 RCF
        {4'd5,  5'h11, 8'h81, 8'h00, 8'h02, 1'b1, 6'b100111}, // R5 RLC C=0
        {4'd5,  5'h11, 8'h40, 8'h00, 8'h81, 1'b1, 6'b001111}, // R5 RLC C=1
        {4'd5,  5'h10, 8'h81, 8'h00, 8'h03, 1'b1, 6'b100111}, // R5 RL
        {4'd5,  5'h13, 8'h01, 8'h00, 8'h80, 1'b1, 6'b101111}, // R5 RRC
        {4'd5,  5'h12, 8'h02, 8'h00, 8'h01, 1'b1, 6'b000011}, // R5 RR
        {4'd6,  5'h14, 8'h81, 8'h00, 8'hC0, 1'b1, 6'b101011}, // R6 SRA
        {4'd7,  5'h15, 8'hFF, 8'h00, 8'h00, 1'b1, 6'b110011}, // R7 COM
        {4'd7,  5'h16, 8'h1E, 8'h00, 8'hE1, 1'b1, 6'b101011}, // R7 SWAP
        {4'd9,  5'h18, 8'h7F, 8'h00, 8'h80, 1'b1, 6'b101111}, // R9 INC
        {4'd9,  5'h19, 8'h00, 8'h00, 8'hFF, 1'b1, 6'b101011}, // R9 DEC wrap
        {4'd9,  5'h19, 8'h01, 8'h00, 8'h00, 1'b1, 6'b110011}, // R9 DEC zero
        {4'd10, 5'h1A, 8'h00, 8'h00, 8'h00, 1'b0, 6'b010011}, // R10 CCF
        {4'd10, 5'h1C, 8'h00, 8'h00, 8'h00, 1'b0, 6'b110011}, // R10 SCF
        {4'd10, 5'h1A, 8'h00, 8'h00, 8'h00, 1'b0, 6'b010011}, // R10 CCF
        {4'd1,  5'h00, 8'h15, 8'h27, 8'h3C, 1'b1, 6'b000000}, // R1
        {4'd8,  5'h17, 8'h3C, 8'h00, 8'h42, 1'b1, 6'b000000}, // R8 low fix
        {4'd1,  5'h00, 8'h99, 8'h01, 8'h9A, 1'b1, 6'b001000}, // R1
        {4'd8,  5'h17, 8'h9A, 8'h00, 8'h00, 1'b1, 6'b110000}, // R8 both fixes
        {4'd1,  5'h00, 8'h09, 8'h09, 8'h12, 1'b1, 6'b000001}, // R1
        {4'd8,  5'h17, 8'h12, 8'h00, 8'h18, 1'b1, 6'b000001}, // R8 H-driven
        {4'd2,  5'h02, 8'h23, 8'h15, 8'h0E, 1'b1, 6'b000011}, // R2
        {4'd8,  5'h17, 8'h0E, 8'h00, 8'h08, 1'b1, 6'b000011}, // R8 subtract 06
        {4'd2,  5'h02, 8'h10, 8'h20, 8'hF0, 1'b1, 6'b101010}, // R2
        {4'd8,  5'h17, 8'hF0, 8'h00, 8'h90, 1'b1, 6'b101010}, // R8 subtract 60
        {4'd11, 5'h08, 8'h55, 8'h33, 8'h00, 1'b0, 6'b101010}  // R11 unused op
    };

    task automatic check(input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [7:0] d,
                         input logic [7:0] s, input logic en);
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; en_i = en;
        #5;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        // R11: reset clears flags even with an operation enabled
        rst_n = 1'b0;
        apply(5'h00, 8'hFF, 8'h01, 1'b1);
        @(posedge clk); #5;
        check(11, "reset flags", {2'b00, flags_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][35:31], VEC[i][30:23], VEC[i][22:15], 1'b1);
            check(int'(VEC[i][39:36]), $sformatf("vec%0d write", i),
                  {7'd0, wr_en_o}, {7'd0, VEC[i][6]});
            if (VEC[i][6])
                check(int'(VEC[i][39:36]), $sformatf("vec%0d result", i),
                      result_o, VEC[i][14:7]);
            @(posedge clk); #5;
            check(int'(VEC[i][39:36]), $sformatf("vec%0d flags", i),
                  {2'b00, flags_o}, {2'b00, VEC[i][5:0]});
        end

        // R11: enable low keeps flags while the result still shows (R1)
        held = flags_o;
        apply(5'h00, 8'hFF, 8'h01, 1'b0);
        check(1, "result with en low", result_o, 8'h00);
        @(posedge clk); #5;
        check(11, "flags held en low", {2'b00, flags_o}, {2'b00, held});

        // R11: reset mid-run clears flags again
        apply(5'h1C, 8'h00, 8'h00, 1'b1);
        @(posedge clk); #5;
        check(10, "SCF before reset", {7'd0, flags_o[5]}, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #5;
        check(11, "mid-run reset flags", {2'b00, flags_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        en_i = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule